// File: doc/BRIEF.md
# Segment-Then-Page Address Translator

This block turns a logical address, given as a segment number and an offset inside that segment, into a physical byte address. It works in two stages. First it reads a per-segment descriptor held in on-block registers. The descriptor holds a valid flag, the segment length and the physical location of that segment's own page table. If the segment is valid and the offset falls inside it, the block makes one read of the segment's page table through a memory read port. The returned entry gives a physical frame number, and the block appends the in-page byte offset to it. Because every segment is spread over fixed-size frames, a segment never needs contiguous physical memory.

Software or a bench fills the descriptors through a write-only load port. The page tables sit in an external memory that is preloaded and answers one cycle after a read is presented. The request side accepts one translation at a time. Each request ends in a single-cycle response that carries a two-bit fault code and the physical address. The address is zero whenever a fault is reported.

Top module: `sgpt_xlate`

## Requirements
- R1: After reset every descriptor is not valid, `req_ready` is 1, and `rsp_valid` and `pt_rd_en` are 0.
- R2: A cycle with `dl_we`=1 writes the valid flag, length and page-table base of segment `dl_seg`. A request to a segment whose valid flag is 0 responds with fault code 2'b01 and issues no page-table read.
- R3: For a valid segment, an offset greater than or equal to the 17-bit segment length responds with fault code 2'b10 and issues no page-table read. A length of 0 faults every offset, and a length of 65536 admits every offset. The invalid-segment fault takes priority over the bounds fault.
- R4: A request that passes both checks issues exactly one page-table read. The address of that read is (base + page_index*2) mod 1024, where page_index is offset bits [15:10].
- R5: A page-table entry is 11 bits. Bit 10 is the present flag and bits [9:0] are the frame number. An entry with bit 10 equal to 0 responds with fault code 2'b11.
- R6: A present entry responds with fault code 2'b00 and `rsp_paddr` = {frame, offset[9:0]}, which is 20 bits.
- R7: A faulting segment or bounds check makes `rsp_valid` high for one cycle, in the cycle after acceptance. On a non-faulting check, `pt_rd_en` is high in the cycle after acceptance, and `rsp_valid` is high two cycles after that.
- R8: `req_ready` is 0 from the cycle after a read-issuing acceptance until the response cycle. A request is accepted only in a cycle where `req_valid` and `req_ready` are both 1.
- R9: A descriptor write to a segment takes effect for requests accepted after the write edge. A translation already in flight keeps the table base it captured at acceptance.
- R10: Whenever a response carries a nonzero fault code, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dl_we | input | 1 | Descriptor write strobe |
| dl_seg | input | 4 | Segment whose descriptor is written |
| dl_valid | input | 1 | Valid flag to store |
| dl_len | input | 17 | Segment length in bytes |
| dl_ptbase | input | 10 | Word address of the segment's page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | 4 | Requested segment number |
| req_off | input | 16 | Byte offset within the segment |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 2 | Fault code: 00 ok, 01 no segment, 10 bounds, 11 page absent |
| rsp_paddr | output | 20 | Translated physical address |
| pt_rd_en | output | 1 | Page-table read request |
| pt_rd_addr | output | 10 | Page-table entry word address |
| pt_rd_data | input | 11 | Entry returned one cycle after the read |

## Verification
On every cycle, the assertions check the following. An accepted request that fails the segment or bounds check never drives a page-table read. Each read lasts exactly one cycle and is followed by a response two cycles later. The request side is busy while a read is outstanding. Faulted responses carry a zero address. A descriptor write lands in the addressed entry. Only the bench's scenarios can show the values themselves: the entry address arithmetic, including wrap past the top of the table memory; the frame splice; the priority between fault causes; the edge offsets at length minus one and at length; and the rule that a rewrite in flight leaves the current translation untouched.

// File: rtl/sgpt_pkg.sv
package sgpt_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_NOSEG  = 2'b01,
    FLT_BOUNDS = 2'b10,
    FLT_NOPAGE = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2
  } xl_state_e;
endpackage

// File: rtl/sgpt_desc_tbl.sv
module sgpt_desc_tbl #(
  parameter int NSEG  = 16,
  parameter int SEG_W = 4,
  parameter int LEN_W = 17,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEG_W-1:0] wseg,
  input  logic             wvalid,
  input  logic [LEN_W-1:0] wlen,
  input  logic [AW-1:0]    wbase,
  input  logic [SEG_W-1:0] rseg,
  output logic             rvalid,
  output logic [LEN_W-1:0] rlen,
  output logic [AW-1:0]    rbase
);
  logic             vld_q  [NSEG];
  logic [LEN_W-1:0] len_q  [NSEG];
  logic [AW-1:0]    base_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic hit;
    assign hit = we && (wseg == SEG_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        len_q[g]  <= '0;
        base_q[g] <= '0;
      end else if (hit) begin
        vld_q[g]  <= wvalid;
        len_q[g]  <= wlen;
        base_q[g] <= wbase;
      end
    end
  end

  assign rvalid = vld_q[rseg];
  assign rlen   = len_q[rseg];
  assign rbase  = base_q[rseg];

  // R2: a load lands in the addressed entry
  assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (vld_q[$past(wseg)] == $past(wvalid)) && (base_q[$past(wseg)] == $past(wbase)));
endmodule

// File: rtl/sgpt_seg_check.sv
module sgpt_seg_check
  import sgpt_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int LEN_W = 17
) (
  input  logic             dvalid,
  input  logic [LEN_W-1:0] dlen,
  input  logic [OFF_W-1:0] off,
  output fault_e           fault
);
  function automatic logic inside_seg(input logic [OFF_W-1:0] o, input logic [LEN_W-1:0] l);
    return LEN_W'(o) < l;
  endfunction

  always_comb begin
    if (!dvalid)                fault = FLT_NOSEG;
    else if (!inside_seg(off, dlen)) fault = FLT_BOUNDS;
    else                        fault = FLT_NONE;
  end
endmodule

// File: rtl/sgpt_xlate.sv
module sgpt_xlate
  import sgpt_pkg::*;
#(
  parameter int NSEG       = 16,
  parameter int OFF_W      = 16,
  parameter int PAGE_BYTES = 1024,
  parameter int PA_W       = 20,
  parameter int PT_AW      = 10,
  parameter int PTE_STRIDE = 2,
  localparam int SEG_W   = $clog2(NSEG),
  localparam int PG_W    = $clog2(PAGE_BYTES),
  localparam int FRAME_W = PA_W - PG_W,
  localparam int LEN_W   = OFF_W + 1,
  localparam int PTE_W   = FRAME_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dl_we,
  input  logic [SEG_W-1:0]   dl_seg,
  input  logic               dl_valid,
  input  logic [LEN_W-1:0]   dl_len,
  input  logic [PT_AW-1:0]   dl_ptbase,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [SEG_W-1:0]   req_seg,
  input  logic [OFF_W-1:0]   req_off,
  output logic               rsp_valid,
  output logic [1:0]         rsp_fault,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               pt_rd_en,
  output logic [PT_AW-1:0]   pt_rd_addr,
  input  logic [PTE_W-1:0]   pt_rd_data
);
  localparam int IDX_W = OFF_W - PG_W;

  function automatic logic [PT_AW-1:0] entry_addr(input logic [PT_AW-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return PT_AW'(int'(base) + int'(idx) * PTE_STRIDE);
  endfunction

  function automatic logic [PA_W-1:0] splice(input logic [FRAME_W-1:0] frame,
                                             input logic [OFF_W-1:0] off);
    return {frame, off[PG_W-1:0]};
  endfunction

  xl_state_e           st;
  logic [OFF_W-1:0]    cur_off;
  logic [PT_AW-1:0]    cur_base;
  logic                rsp_valid_q;
  fault_e              fault_q;
  logic [PA_W-1:0]     paddr_q;

  logic                d_valid;
  logic [LEN_W-1:0]    d_len;
  logic [PT_AW-1:0]    d_base;
  fault_e              chk_fault;

  // named events for the checks
  logic                accept;
  logic                issue_rd;
  logic                pte_present;
  logic [FRAME_W-1:0]  pte_frame;

  sgpt_desc_tbl #(.NSEG(NSEG), .SEG_W(SEG_W), .LEN_W(LEN_W), .AW(PT_AW)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .we(dl_we), .wseg(dl_seg), .wvalid(dl_valid), .wlen(dl_len), .wbase(dl_ptbase),
    .rseg(req_seg), .rvalid(d_valid), .rlen(d_len), .rbase(d_base)
  );

  sgpt_seg_check #(.OFF_W(OFF_W), .LEN_W(LEN_W)) u_chk (
    .dvalid(d_valid), .dlen(d_len), .off(req_off), .fault(chk_fault)
  );

  assign req_ready   = (st == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign issue_rd    = (st == ST_READ);
  assign pte_present = pt_rd_data[PTE_W-1];
  assign pte_frame   = pt_rd_data[FRAME_W-1:0];

  assign pt_rd_en   = issue_rd;
  assign pt_rd_addr = entry_addr(cur_base, cur_off[OFF_W-1:PG_W]);
  assign rsp_valid  = rsp_valid_q;
  assign rsp_fault  = fault_q;
  assign rsp_paddr  = paddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cur_off     <= '0;
      cur_base    <= '0;
      rsp_valid_q <= 1'b0;
      fault_q     <= FLT_NONE;
      paddr_q     <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          cur_off  <= req_off;
          cur_base <= d_base;
          if (chk_fault != FLT_NONE) begin
            rsp_valid_q <= 1'b1;
            fault_q     <= chk_fault;
            paddr_q     <= '0;
          end else begin
            st <= ST_READ;
          end
        end
        ST_READ: st <= ST_WAIT;
        ST_WAIT: begin
          st          <= ST_IDLE;
          rsp_valid_q <= 1'b1;
          if (pte_present) begin
            fault_q <= FLT_NONE;
            paddr_q <= splice(pte_frame, cur_off);
          end else begin
            fault_q <= FLT_NOPAGE;
            paddr_q <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3 (and R2): a failed check never reaches the page table
  assert_no_read_on_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (chk_fault != FLT_NONE)) |=> !pt_rd_en);
  // R4: one read per translation
  assert_single_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd_en |=> !pt_rd_en);
  // R7: response two cycles after the read
  assert_rsp_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd_en |=> ##1 rsp_valid);
  // R8: busy while a read is outstanding
  assert_busy_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd_en |-> !req_ready);
  // R10: faulted responses carry no address
  assert_fault_zero_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault != 2'b00)) |-> (rsp_paddr == '0));
endmodule

// File: tb/tb_sgpt_xlate.sv
`timescale 1ns/1ps
module tb_sgpt_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dl_we = 1'b0;
  logic [3:0]  dl_seg = '0;
  logic        dl_valid = 1'b0;
  logic [16:0] dl_len = '0;
  logic [9:0]  dl_ptbase = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_seg = '0;
  logic [15:0] req_off = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [19:0] rsp_paddr;
  logic        pt_rd_en;
  logic [9:0]  pt_rd_addr;
  logic [10:0] pt_rd_data = '0;

  always #2.5 clk = ~clk;

  sgpt_xlate dut (
    .clk(clk), .rst_n(rst_n), .dl_we(dl_we), .dl_seg(dl_seg), .dl_valid(dl_valid),
    .dl_len(dl_len), .dl_ptbase(dl_ptbase), .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .pt_rd_en(pt_rd_en), .pt_rd_addr(pt_rd_addr), .pt_rd_data(pt_rd_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench-side models
  int mem [1024];
  bit m_v [16];
  int m_len [16];
  int m_base [16];

  typedef struct { int fault; int paddr; string tag; } exp_t;
  exp_t sb_q [$];
  int exp_rd_addr = -1;
  int n_reads = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // page-table memory: one-cycle read
  always @(posedge clk) if (pt_rd_en) pt_rd_data <= 11'(mem[pt_rd_addr]);

  // read monitor
  always @(negedge clk) if (rst_n && pt_rd_en) begin
    n_reads++;
    check(int'(pt_rd_addr) == exp_rd_addr, "R4 entry address", int'(pt_rd_addr), exp_rd_addr);
  end

  // response monitor / scoreboard
  always @(negedge clk) if (rst_n && rsp_valid) begin
    exp_t e;
    if (sb_q.size() == 0) begin
      check(1'b0, "R7 unexpected response", 1, 0);
    end else begin
      e = sb_q.pop_front();
      check(int'(rsp_fault) == e.fault, {e.tag, " fault"}, int'(rsp_fault), e.fault);
      check(int'(rsp_paddr) == e.paddr, {e.tag, " paddr"}, int'(rsp_paddr), e.paddr);
    end
  end

  function automatic void predict(input int seg, input int off,
                                  output int f, output int pa, output int ra);
    int pte;
    ra = -1; pa = 0;
    if (!m_v[seg]) f = 1;
    else if (off >= m_len[seg]) f = 2;
    else begin
      ra  = (m_base[seg] + (off / 1024) * 2) % 1024;
      pte = mem[ra];
      if (pte >= 1024) begin f = 0; pa = (pte % 1024) * 1024 + (off % 1024); end
      else f = 3;
    end
  endfunction

  task automatic load(input int seg, input bit v, input int len, input int base);
    @(negedge clk);
    dl_we = 1'b1; dl_seg = 4'(seg); dl_valid = v; dl_len = 17'(len); dl_ptbase = 10'(base);
    @(negedge clk);
    dl_we = 1'b0;
    m_v[seg] = v; m_len[seg] = len; m_base[seg] = base;
  endtask

  task automatic send(input int seg, input int off, input string tag,
                      input bit rw = 1'b0, input int rw_len = 0, input int rw_base = 0);
    int f, pa, ra, lat, reads0, exp_lat;
    exp_t e;
    @(negedge clk);
    predict(seg, off, f, pa, ra);
    e.fault = f; e.paddr = pa; e.tag = tag;
    sb_q.push_back(e);
    exp_rd_addr = ra;
    reads0 = n_reads;
    req_valid = 1'b1; req_seg = 4'(seg); req_off = 16'(off);
    check(req_ready == 1'b1, "R8 ready when idle", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (ra >= 0) check(req_ready == 1'b0, "R8 busy after accept", int'(req_ready), 0);
    if (rw) begin
      dl_we = 1'b1; dl_seg = 4'(seg); dl_valid = 1'b1; dl_len = 17'(rw_len); dl_ptbase = 10'(rw_base);
    end
    while (!rsp_valid && lat < 8) begin
      @(negedge clk);
      lat++;
      if (dl_we) begin
        dl_we = 1'b0;
        m_v[seg] = 1'b1; m_len[seg] = rw_len; m_base[seg] = rw_base;
      end
    end
    exp_lat = (ra >= 0) ? 3 : 1;
    check(lat == exp_lat, "R7 latency", lat, exp_lat);
    check((n_reads - reads0) == ((ra >= 0) ? 1 : 0), "R3 R4 read count", n_reads - reads0, (ra >= 0) ? 1 : 0);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int lcg;
    for (int i = 0; i < 1024; i++) mem[i] = (((i % 5) != 3) ? 1024 : 0) + ((i * 37 + 5) % 1024);
    for (int i = 0; i < 16; i++) begin m_v[i] = 1'b0; m_len[i] = 0; m_base[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    check(pt_rd_en == 1'b0, "R1 rd_en", int'(pt_rd_en), 0);
    rst_n = 1'b1;
    send(3, 16'h0100, "R1 descriptor invalid after reset");

    load(0, 1'b1, 17'h04000, 0);
    load(5, 1'b1, 17'h10000, 10'h3F0);
    load(7, 1'b0, 17'h10000, 10'h020);
    load(9, 1'b1, 0, 10'h100);

    send(0, 16'h0000, "R6 first byte");
    send(0, 16'h03FF, "R6 last byte of page");
    send(0, 16'h0400, "R6 second page");
    send(0, 16'h3FFF, "R3 length minus one");
    send(0, 16'h4000, "R3 offset equals length");
    send(0, 16'h1000, "R5 absent page");
    send(5, 16'hFFFF, "R3 full length R4 wrap");
    send(5, 16'h8123, "R4 wrap");
    send(7, 16'h0000, "R2 loaded invalid");
    send(7, 16'hFFFF, "R3 invalid outranks bounds");
    send(9, 16'h0000, "R3 zero length");
    // R9: rewrite during flight keeps captured base
    send(0, 16'h0800, "R9 in flight", 1'b1, 17'h00010, 10'h100);
    send(0, 16'h0800, "R9 after rewrite");
    send(0, 16'h000F, "R9 new base");
    // R10: fault addresses zero, several patterns
    lcg = 7;
    for (int k = 0; k < 40; k++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7FFFFFFF;
      send(((lcg >> 8) % 2 == 0) ? 5 : 0, (lcg >> 4) % 65536, "R6 R10 sweep");
    end
    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R7 all responses seen", sb_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule